// File: doc/BRIEF.md
# Two-Bus Register Datapath with ALU Result Register

This block is a small register-file datapath with two transfer buses. When a command is accepted, both source registers are placed on the buses in the same cycle, one on each bus, and fed together into a combinational ALU. Both buses are taken by the operands in that cycle, so the ALU output cannot travel on a bus yet. It is captured in a dedicated result register instead. In the following cycle the result register drives bus A and the value is written into the destination register. Bus B stays idle in that cycle.

Each operation takes two cycles: an operand cycle and a writeback cycle. A command names two source indices, a destination index and a 4-bit function code, and is issued with a start strobe while the block is idle. A separate load port writes a register directly while the block is idle. The two buses are brought out as outputs so that the transfers on them can be observed.

Top module: `dual_bus_alu_dp`

## Requirements
- R1: After reset, busy_o and done_o are low, both buses read zero, and every register holds zero.
- R2: While idle, a load strobe writes ld_data_i into register ld_idx_i at the clock edge. A load strobe while busy_o is high has no effect.
- R3: A start while idle is accepted at the clock edge. In the cycle after that edge busy_o is high, done_o is low, bus A carries the register selected by the latched source A index and bus B carries the register selected by the latched source B index.
- R4: In the second cycle after acceptance, bus A carries the ALU result, bus B is zero, and busy_o and done_o are both high. done_o is high for exactly one cycle. The result is written to the destination register at the end of that cycle.
- R5: busy_o stays high for exactly two cycles per accepted command and then returns low.
- R6: A start seen while busy_o is high, including in the done cycle, is ignored. It does not extend the operation, does not add a done pulse and does not write a register.
- R7: Arithmetic codes wrap modulo 2^DATA_W: 0 = A+B, 1 = A-B, 10 = A+1, 11 = A-1.
- R8: Logic codes: 2 = A AND B, 3 = A OR B, 4 = A XOR B, 5 = NOT A, 12 = NOT (A OR B).
- R9: Move, shift and compare codes: 6 = A, 7 = B, 8 = A shifted left by one, 9 = A shifted right by one with zero fill, 13 = 1 if A < B (unsigned) else 0, 14 = A shifted right by one with the sign bit kept, 15 = 0.
- R10: While busy_o is low, both buses are zero.
- R11: The source indices may be equal to each other and to the destination. Both operands are read before the destination is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Issue the command, accepted only while idle |
| src_a_i | input | IDX_W | Register index driven onto bus A |
| src_b_i | input | IDX_W | Register index driven onto bus B |
| dst_i | input | IDX_W | Destination register index |
| func_i | input | 4 | ALU function code |
| ld_en_i | input | 1 | Direct register load strobe, honoured only while idle |
| ld_idx_i | input | IDX_W | Load target register |
| ld_data_i | input | DATA_W | Load value |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle pulse in the writeback cycle |
| bus_a_o | output | DATA_W | Value on bus A |
| bus_b_o | output | DATA_W | Value on bus B |

## Verification
The bound checker checks the timing skeleton on every cycle. It covers acceptance into the operand cycle, done arriving exactly two cycles after acceptance, a single-cycle done pulse, the return to idle after done whatever start does, bus B idle during writeback and both buses zero while idle. The values on the buses depend on register contents and the ALU code, so only the bench's scoreboard shows them. It models the register file and compares the operands and results for every function code, including wrap, sign-preserving shift and same-register cases. The bench's scenarios also show that a load or start during a busy cycle leaves the registers untouched, by reading the affected register back afterwards.

// File: rtl/dbd_pkg.sv
package dbd_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_NOTA = 4'd5,
    OP_PASA = 4'd6,
    OP_PASB = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHR  = 4'd9,
    OP_INC  = 4'd10,
    OP_DEC  = 4'd11,
    OP_NOR  = 4'd12,
    OP_SLTU = 4'd13,
    OP_ASR  = 4'd14,
    OP_ZERO = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OPER = 2'd1,
    PH_WB   = 2'd2
  } phase_e;
endpackage

// File: rtl/dbd_alu.sv
module dbd_alu
  import dbd_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] y_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    unique case (op_i)
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      OP_NOTA: y_o = ~a_i;
      OP_PASA: y_o = a_i;
      OP_PASB: y_o = b_i;
      OP_SHL:  y_o = {a_i[DATA_W-2:0], 1'b0};
      OP_SHR:  y_o = {1'b0, a_i[DATA_W-1:1]};
      OP_INC:  y_o = a_i + ONE;
      OP_DEC:  y_o = a_i - ONE;
      OP_NOR:  y_o = ~(a_i | b_i);
      OP_SLTU: y_o = (a_i < b_i) ? ONE : '0;
      OP_ASR:  y_o = {a_i[DATA_W-1], a_i[DATA_W-1:1]};
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/dbd_regfile.sv
module dbd_regfile #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_a_i,
  input  logic [IDX_W-1:0]  ridx_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (we_i && (widx_i == IDX_W'(g))) regs_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[ridx_a_i];
  assign rdata_b_o = regs_q[ridx_b_i];
endmodule

// File: rtl/dbd_ctrl.sv
module dbd_ctrl
  import dbd_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] src_a_i,
  input  logic [IDX_W-1:0] src_b_i,
  input  logic [IDX_W-1:0] dst_i,
  input  logic [3:0]       func_i,
  output phase_e           phase_o,
  output logic [IDX_W-1:0] src_a_o,
  output logic [IDX_W-1:0] src_b_o,
  output logic [IDX_W-1:0] dst_o,
  output alu_op_e          op_o
);
  phase_e phase_q, phase_d;
  logic   accept;

  assign accept = start_i && (phase_q == PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) phase_d = PH_OPER;
      PH_OPER: phase_d = PH_WB;
      PH_WB:   phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      src_a_o <= '0;
      src_b_o <= '0;
      dst_o   <= '0;
      op_o    <= OP_ADD;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        src_a_o <= src_a_i;
        src_b_o <= src_b_i;
        dst_o   <= dst_i;
        op_o    <= alu_op_e'(func_i);
      end
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/dual_bus_alu_dp.sv
module dual_bus_alu_dp
  import dbd_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  src_a_i,
  input  logic [IDX_W-1:0]  src_b_i,
  input  logic [IDX_W-1:0]  dst_i,
  input  logic [3:0]        func_i,
  input  logic              ld_en_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] bus_a_o,
  output logic [DATA_W-1:0] bus_b_o
);
  phase_e            phase;
  logic [IDX_W-1:0]  src_a, src_b, dst;
  alu_op_e           op;
  logic [DATA_W-1:0] rd_a, rd_b, alu_y, res_q;
  logic              in_oper, in_wb, in_idle;
  logic              rf_we;
  logic [IDX_W-1:0]  rf_widx;
  logic [DATA_W-1:0] rf_wdata;

  dbd_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .src_a_i (src_a_i),
    .src_b_i (src_b_i),
    .dst_i   (dst_i),
    .func_i  (func_i),
    .phase_o (phase),
    .src_a_o (src_a),
    .src_b_o (src_b),
    .dst_o   (dst),
    .op_o    (op)
  );

  assign in_idle = (phase == PH_IDLE);
  assign in_oper = (phase == PH_OPER);
  assign in_wb   = (phase == PH_WB);

  // Two buses: operands share the operand cycle, result rides bus A in writeback
  always_comb begin
    bus_a_o = '0;
    bus_b_o = '0;
    if (in_oper) begin
      bus_a_o = rd_a;
      bus_b_o = rd_b;
    end else if (in_wb) begin
      bus_a_o = res_q;
    end
  end

  dbd_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i  (bus_a_o),
    .b_i  (bus_b_o),
    .op_i (op),
    .y_o  (alu_y)
  );

  // Result register: no bus is free in the operand cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      res_q <= '0;
    else if (in_oper) res_q <= alu_y;
  end

  assign rf_we    = in_wb || (in_idle && ld_en_i);
  assign rf_widx  = in_wb ? dst : ld_idx_i;
  assign rf_wdata = in_wb ? bus_a_o : ld_data_i;

  dbd_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .widx_i    (rf_widx),
    .wdata_i   (rf_wdata),
    .ridx_a_i  (src_a),
    .ridx_b_i  (src_b),
    .rdata_a_o (rd_a),
    .rdata_b_o (rd_b)
  );

  assign busy_o = !in_idle;
  assign done_o = in_wb;
endmodule

// File: rtl/dbd_checker.sv
module dbd_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] bus_a_o,
  input logic [DATA_W-1:0] bus_b_o
);
  // R3
  accept_to_oper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o));

  // R5
  accept_to_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> ##1 done_o);

  // R4
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  wb_bus_b_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_o && bus_b_o == '0));

  // R6
  done_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  // R6
  oper_to_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> done_o);

  // R10
  idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (bus_a_o == '0 && bus_b_o == '0));
endmodule

bind dual_bus_alu_dp dbd_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .bus_a_o (bus_a_o),
  .bus_b_o (bus_b_o)
);

// File: tb/tb_dual_bus_alu_dp.sv
`timescale 1ns/1ps
module tb_dual_bus_alu_dp;
  localparam int W  = 16;
  localparam int N  = 8;
  localparam int IW = $clog2(N);

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] r;
    string        tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [IW-1:0] src_a = '0, src_b = '0, dst = '0;
  logic [3:0]    func = '0;
  logic          ld_en = 1'b0;
  logic [IW-1:0] ld_idx = '0;
  logic [W-1:0]  ld_data = '0;
  logic          busy, done;
  logic [W-1:0]  bus_a, bus_b;

  int checks = 0;
  int failures = 0;
  int ops_issued = 0;
  int dones_seen = 0;
  exp_t sb[$];
  logic [W-1:0] model [N];

  always #2.5 clk = ~clk;

  dual_bus_alu_dp #(.DATA_W(W), .NUM_REGS(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .src_a_i(src_a),
    .src_b_i(src_b), .dst_i(dst), .func_i(func), .ld_en_i(ld_en),
    .ld_idx_i(ld_idx), .ld_data_i(ld_data), .busy_o(busy), .done_o(done),
    .bus_a_o(bus_a), .bus_b_o(bus_b)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] alu_ref(int f, logic [W-1:0] a, logic [W-1:0] b);
    case (f)
      0:  return a + b;
      1:  return a - b;
      2:  return a & b;
      3:  return a | b;
      4:  return a ^ b;
      5:  return ~a;
      6:  return a;
      7:  return b;
      8:  return a << 1;
      9:  return a >> 1;
      10: return a + 1'b1;
      11: return a - 1'b1;
      12: return ~(a | b);
      13: return (a < b) ? W'(1) : W'(0);
      14: return {a[W-1], a[W-1:1]};
      default: return '0;
    endcase
  endfunction

  // Monitor: operand cycle and writeback cycle against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !done) begin
        if (sb.size() == 0) chk("R6 operand cycle with no command", 1'b1, 1'b0);
        else begin
          chk({"R3 bus A operand ", sb[0].tag}, bus_a, sb[0].a);
          chk({"R3 bus B operand ", sb[0].tag}, bus_b, sb[0].b);
        end
      end
      if (done) begin
        dones_seen++;
        if (sb.size() == 0) chk("R6 done with no command", 1'b1, 1'b0);
        else begin
          chk({"R4 result ", sb[0].tag}, bus_a, sb[0].r);
          chk("R4 bus B idle in writeback", bus_b, '0);
          void'(sb.pop_front());
        end
      end
    end
  end

  task automatic load(int idx, logic [W-1:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = IW'(idx); ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
    model[idx] = v;
  endtask

  // Issue one command; optionally drive a load and a start during the busy cycles
  task automatic do_op(int sa, int sb_i, int d, int f, string tag, bit interfere = 0,
                       int kidx = 0);
    exp_t e;
    e.a = model[sa]; e.b = model[sb_i]; e.r = alu_ref(f, e.a, e.b); e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b1; src_a = IW'(sa); src_b = IW'(sb_i); dst = IW'(d); func = 4'(f);
    @(negedge clk);
    ops_issued++;
    if (interfere) begin
      start = 1'b1; src_a = IW'(kidx); src_b = IW'(kidx); dst = IW'(kidx); func = 4'd15;
      ld_en = 1'b1; ld_idx = IW'(kidx); ld_data = 16'hDEAD;
    end else start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R5 busy low after two cycles", W'(busy), '0);
    start = 1'b0; ld_en = 1'b0;
    model[d] = e.r;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy after reset", W'(busy), '0);
    chk("R1 done after reset", W'(done), '0);
    chk("R10 bus A idle", bus_a, '0);
    chk("R10 bus B idle", bus_b, '0);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) do_op(i, i, i, 6, "R1 register zero after reset");

    // R2 loads
    load(1, 16'h1234); load(2, 16'h00F0); load(3, 16'hFFFF);
    load(4, 16'h8001); load(5, 16'h0001); load(6, 16'h7FFE); load(7, 16'h0000);
    for (int i = 1; i < N; i++) do_op(i, i, i, 6, "R2 load readback");

    // R7 arithmetic with wrap
    do_op(3, 5, 0, 0, "R7 add wrap FFFF+1");
    do_op(7, 5, 0, 1, "R7 sub wrap 0-1");
    do_op(1, 2, 0, 0, "R7 add");
    do_op(1, 2, 0, 1, "R7 sub");
    do_op(3, 2, 0, 10, "R7 inc wrap");
    do_op(7, 2, 0, 11, "R7 dec wrap");
    // R8 logic
    do_op(1, 2, 0, 2, "R8 and");
    do_op(1, 2, 0, 3, "R8 or");
    do_op(1, 3, 0, 4, "R8 xor");
    do_op(1, 2, 0, 5, "R8 not");
    do_op(1, 2, 0, 12, "R8 nor");
    // R9 move, shift, compare
    do_op(4, 1, 0, 7, "R9 pass B");
    do_op(4, 1, 0, 8, "R9 shl");
    do_op(4, 1, 0, 9, "R9 shr");
    do_op(4, 1, 0, 14, "R9 asr negative");
    do_op(6, 1, 0, 14, "R9 asr positive");
    do_op(5, 3, 0, 13, "R9 sltu true");
    do_op(3, 5, 0, 13, "R9 sltu false");
    do_op(1, 1, 0, 13, "R9 sltu equal");
    do_op(1, 2, 0, 15, "R9 zero");
    // R11 same register as both sources and destination
    do_op(6, 6, 6, 0, "R11 r6+r6 into r6");
    do_op(6, 5, 6, 1, "R11 r6-r5 into r6");
    do_op(6, 6, 6, 6, "R11 readback r6");
    // R6 and R2: start and load during busy are ignored
    do_op(1, 5, 2, 0, "R6 op under interference", 1'b1, 3);
    do_op(3, 3, 3, 6, "R2 r3 untouched by busy load");
    do_op(2, 2, 2, 6, "R6 r2 holds op result");
    do_op(4, 4, 0, 6, "R6 dest of ignored start");

    repeat (3) @(negedge clk);
    chk("R6 done count", W'(dones_seen), W'(ops_issued));
    chk("R4 scoreboard drained", W'(sb.size()), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule